// File: doc/BRIEF.md
# I2C Two-Stage Baud Rate Prescaler

This block derives the bit timing of an I2C master from the system clock. An eight-bit-free, seven-bit rate word packs a linear factor and a binary exponent. A power-of-two stage first divides the clock by 2^N. A linear stage then divides that rate by M+1 and emits a one-cycle oversample tick. Ten ticks make one SCL period, so the SCL rate is Fclk / (10·(M+1)·2^N).

A phase sequencer counts the ticks and drives the SCL level: low for the first five ticks of a period and high for the last five. It also issues two quarter-phase strobes. The first marks the point in the low half where SDA may change. The second marks the point in the high half where SDA is sampled. The bus engine raises `run` to time a transfer and lowers it when the bus is idle.

A new rate word is held pending while `run` is high. It reaches the counters only when the bus is idle. A synchronous soft reset restores the default rate word and restarts all timing.

Top module: `i2c_baud_gen`

## Requirements
- R1: After the asynchronous reset, `cfg_active` is 0x44 (M=8, N=4), `scl_o` is 1 and `tick` is 0.
- R2: The rate word encodes M in bits [6:3] and N in bits [2:0].
- R3: While `run` is high, consecutive `tick` pulses are exactly (M+1)·2^N clock cycles apart.
- R4: One SCL period lasts ten ticks. `scl_o` is low from the first cycle with `run` high until the fifth tick, and high from the cycle after the fifth tick until the tenth tick. The period then repeats from low. `scl_o` changes only after a tick, or when `run` or `soft_rst` changes.
- R5: `sda_chg_stb` pulses together with the third tick of each period, while `scl_o` is low. `sda_smp_stb` pulses with the eighth tick, while `scl_o` is high. `period_end` pulses with the tenth tick.
- R6: While `run` is low, `tick` and all strobes stay 0 and `scl_o` stays 1. After `run` rises, the first tick comes in the (M+1)·2^N-th cycle in which `run` is high.
- R7: A write made while `run` is high leaves `cfg_active` and the tick spacing unchanged. The written value becomes active one clock after `run` falls.
- R8: A write made while `run` is low appears on `cfg_active` after the next clock edge.
- R9: `soft_rst` returns both the pending and the active rate word to 0x44 and takes precedence over a write in the same cycle. During `soft_rst`, `tick` is 0 and `scl_o` is 1. Afterwards, timing restarts from phase zero.

Top module ports follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_rst | input | 1 | Synchronous soft reset to the default rate |
| cfg_we | input | 1 | Write strobe for the rate word |
| cfg_wdata | input | 7 | Rate word, M in [6:3], N in [2:0] |
| run | input | 1 | High while the bus engine times a transfer; low means bus idle |
| cfg_active | output | 7 | Rate word currently used by the dividers |
| tick | output | 1 | Oversample tick, ten per SCL period |
| scl_o | output | 1 | SCL level (1 = released high) |
| sda_chg_stb | output | 1 | SDA change point in the low half |
| sda_smp_stb | output | 1 | SDA sample point in the high half |
| period_end | output | 1 | Last tick of an SCL period |

## Verification
A soft reset and a rate write can arrive in the same cycle. The bench provokes this in two ways: with a pending value already held during a transfer, and with a fresh write driven alongside `soft_rst`. The bench judges the outcome in three places. `cfg_active` must read 0x44 after the edge. The following tick must land 144 cycles later. After `run` falls, `cfg_active` must still read 0x44, which shows the pending write was discarded too. The same collision also shows that the quiet-output rule wins over a running phase count.

// File: rtl/i2cbr_pkg.sv
package i2cbr_pkg;

    // Oversample ticks per SCL period and the split points inside it
    localparam int OVS_DEF     = 10;
    localparam int LOW_DEF     = 5;
    localparam int CHG_PH_DEF  = 2;
    localparam int SMP_PH_DEF  = 7;

    // Bits needed to count n states
    function automatic int cnt_bits(input int n);
        return (n <= 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/i2cbr_cfg.sv
module i2cbr_cfg #(
    parameter int             CFG_W   = 7,
    parameter logic [CFG_W-1:0] CFG_DEF = 7'h44
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             soft_rst,
    input  logic             wr_en,
    input  logic [CFG_W-1:0] wr_data,
    input  logic             bus_idle,
    output logic [CFG_W-1:0] active
);

    typedef struct packed {
        logic [CFG_W-1:0] pend;
        logic [CFG_W-1:0] act;
    } cfg_st_t;

    cfg_st_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (wr_en) begin
            s_d.pend = wr_data;
        end
        if (bus_idle) begin
            s_d.act = wr_en ? wr_data : s_q.pend;
        end
        if (soft_rst) begin
            s_d.pend = CFG_DEF;
            s_d.act  = CFG_DEF;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{pend: CFG_DEF, act: CFG_DEF};
        end else begin
            s_q <= s_d;
        end
    end

    assign active = s_q.act;

endmodule

// File: rtl/i2cbr_pow2.sv
module i2cbr_pow2 #(
    parameter int N_W = 3
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           clr,
    input  logic [N_W-1:0] expo,
    output logic           step
);

    localparam int PRE_W = (1 << N_W) - 1;

    typedef struct packed {
        logic [PRE_W-1:0] cnt;
    } pre_st_t;

    pre_st_t s_d, s_q;
    logic [PRE_W-1:0] lim;

    // 2^expo - 1 as a run of low ones
    assign lim  = ~({PRE_W{1'b1}} << expo);
    assign step = !clr && (s_q.cnt == lim);

    always_comb begin
        s_d = s_q;
        if (clr || step) begin
            s_d.cnt = '0;
        end else begin
            s_d.cnt = s_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

endmodule

// File: rtl/i2cbr_lin.sv
module i2cbr_lin #(
    parameter int M_W = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           clr,
    input  logic           step_in,
    input  logic [M_W-1:0] mult,
    output logic           tick
);

    typedef struct packed {
        logic [M_W-1:0] cnt;
    } lin_st_t;

    lin_st_t s_d, s_q;

    assign tick = step_in && (s_q.cnt == mult);

    always_comb begin
        s_d = s_q;
        if (clr || tick) begin
            s_d.cnt = '0;
        end else if (step_in) begin
            s_d.cnt = s_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

endmodule

// File: rtl/i2cbr_phase.sv
module i2cbr_phase #(
    parameter int OVS    = 10,
    parameter int LOW    = 5,
    parameter int CHG_PH = 2,
    parameter int SMP_PH = 7
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic tick,
    output logic scl,
    output logic chg_stb,
    output logic smp_stb,
    output logic per_end
);

    localparam int PH_W = i2cbr_pkg::cnt_bits(OVS);
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(OVS - 1);
    localparam logic [PH_W-1:0] PH_LOW  = PH_W'(LOW);
    localparam logic [PH_W-1:0] PH_CHG  = PH_W'(CHG_PH);
    localparam logic [PH_W-1:0] PH_SMP  = PH_W'(SMP_PH);

    typedef struct packed {
        logic [PH_W-1:0] ph;
    } ph_st_t;

    ph_st_t s_d, s_q;

    assign scl     = clr || (s_q.ph >= PH_LOW);
    assign chg_stb = tick && (s_q.ph == PH_CHG);
    assign smp_stb = tick && (s_q.ph == PH_SMP);
    assign per_end = tick && (s_q.ph == PH_LAST);

    always_comb begin
        s_d = s_q;
        if (clr || per_end) begin
            s_d.ph = '0;
        end else if (tick) begin
            s_d.ph = s_q.ph + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

endmodule

// File: rtl/i2c_baud_gen.sv
module i2c_baud_gen #(
    parameter int                   M_W     = 4,
    parameter int                   N_W     = 3,
    parameter logic [M_W+N_W-1:0]   CFG_DEF = 7'h44,
    parameter int                   OVS     = i2cbr_pkg::OVS_DEF,
    parameter int                   LOW     = i2cbr_pkg::LOW_DEF,
    parameter int                   CHG_PH  = i2cbr_pkg::CHG_PH_DEF,
    parameter int                   SMP_PH  = i2cbr_pkg::SMP_PH_DEF
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               soft_rst,
    input  logic               cfg_we,
    input  logic [M_W+N_W-1:0] cfg_wdata,
    input  logic               run,
    output logic [M_W+N_W-1:0] cfg_active,
    output logic               tick,
    output logic               scl_o,
    output logic               sda_chg_stb,
    output logic               sda_smp_stb,
    output logic               period_end
);

    localparam int CFG_W = M_W + N_W;

    logic           clr;
    logic           pre_step;
    logic [M_W-1:0] mult;
    logic [N_W-1:0] expo;

    assign clr  = !run || soft_rst;
    assign mult = cfg_active[CFG_W-1:N_W];
    assign expo = cfg_active[N_W-1:0];

    i2cbr_cfg #(.CFG_W(CFG_W), .CFG_DEF(CFG_DEF)) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .soft_rst(soft_rst),
        .wr_en   (cfg_we),
        .wr_data (cfg_wdata),
        .bus_idle(!run),
        .active  (cfg_active)
    );

    i2cbr_pow2 #(.N_W(N_W)) u_pow2 (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (clr),
        .expo (expo),
        .step (pre_step)
    );

    i2cbr_lin #(.M_W(M_W)) u_lin (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (clr),
        .step_in(pre_step),
        .mult   (mult),
        .tick   (tick)
    );

    i2cbr_phase #(.OVS(OVS), .LOW(LOW), .CHG_PH(CHG_PH), .SMP_PH(SMP_PH)) u_phase (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (clr),
        .tick   (tick),
        .scl    (scl_o),
        .chg_stb(sda_chg_stb),
        .smp_stb(sda_smp_stb),
        .per_end(period_end)
    );

endmodule

// File: rtl/i2cbr_chk.sv
module i2cbr_chk #(
    parameter int                 CFG_W   = 7,
    parameter logic [CFG_W-1:0]   CFG_DEF = 7'h44
) (
    input logic             clk,
    input logic             rst_n,
    input logic             soft_rst,
    input logic             run,
    input logic [CFG_W-1:0] cfg_active,
    input logic             tick,
    input logic             scl_o,
    input logic             sda_chg_stb,
    input logic             sda_smp_stb,
    input logic             period_end
);

    p_strobe_on_tick_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_chg_stb || sda_smp_stb || period_end) |-> tick);

    p_chg_in_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
        sda_chg_stb |-> !scl_o);

    p_smp_in_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
        sda_smp_stb |-> scl_o);

    p_idle_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!run || soft_rst) |-> (!tick && scl_o));

    p_cfg_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(run) && !$past(soft_rst)) |-> $stable(cfg_active));

    p_soft_default_r9: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (cfg_active == CFG_DEF));

    p_scl_moves_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(scl_o) |-> ($past(tick) || !run || soft_rst || !$past(run) || $past(soft_rst)));

endmodule

bind i2c_baud_gen i2cbr_chk #(.CFG_W(CFG_W), .CFG_DEF(CFG_DEF)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .soft_rst   (soft_rst),
    .run        (run),
    .cfg_active (cfg_active),
    .tick       (tick),
    .scl_o      (scl_o),
    .sda_chg_stb(sda_chg_stb),
    .sda_smp_stb(sda_smp_stb),
    .period_end (period_end)
);

// File: tb/sim_i2c_baud_gen.sv
module sim_i2c_baud_gen;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       soft_rst = 1'b0;
    logic       cfg_we = 1'b0;
    logic [6:0] cfg_wdata = '0;
    logic       run = 1'b0;
    logic [6:0] cfg_active;
    logic       tick, scl_o, sda_chg_stb, sda_smp_stb, period_end;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    i2c_baud_gen u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .soft_rst   (soft_rst),
        .cfg_we     (cfg_we),
        .cfg_wdata  (cfg_wdata),
        .run        (run),
        .cfg_active (cfg_active),
        .tick       (tick),
        .scl_o      (scl_o),
        .sda_chg_stb(sda_chg_stb),
        .sda_smp_stb(sda_smp_stb),
        .period_end (period_end)
    );

    // rate word and expected tick spacing in clocks, (M+1)*2^N
    typedef struct packed {
        logic [6:0]  cfg;
        logic [15:0] per;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VECS [NV] = '{
        '{7'h00, 16'd1},    // M=0  N=0
        '{7'h08, 16'd2},    // M=1  N=0
        '{7'h01, 16'd2},    // M=0  N=1
        '{7'h1A, 16'd16},   // M=3  N=2
        '{7'h78, 16'd16},   // M=15 N=0
        '{7'h2B, 16'd48},   // M=5  N=3
        '{7'h07, 16'd128},  // M=0  N=7
        '{7'h44, 16'd144},  // M=8  N=4 default
        '{7'h7F, 16'd2048}  // M=15 N=7
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    task automatic idle_write(input logic [6:0] w);
        @(negedge clk);
        run = 1'b0; cfg_we = 1'b1; cfg_wdata = w;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // One full SCL period from the rise of run
    task automatic run_vector(input logic [6:0] w, input int p);
        int t1 = 0, t2 = 0, ticks = 0, lows = 0, rise = 0;
        int chg_at = 0, smp_at = 0, end_at = 0;
        idle_write(w);
        #1;
        chk(cfg_active == w, "R8 active after idle write", cfg_active, w);
        chk(((int'(w[6:3]) + 1) << w[2:0]) == p, "R2 field decode of table entry",
            (int'(w[6:3]) + 1) << w[2:0], p);
        @(negedge clk);
        run = 1'b1;
        for (int c = 1; c <= 10 * p; c++) begin
            #1;
            if (tick) begin
                ticks++;
                if (t1 == 0) t1 = c;
                else if (t2 == 0) t2 = c;
            end
            if (!scl_o) lows++;
            if (scl_o && rise == 0) rise = c;
            if (sda_chg_stb && !scl_o) chg_at = c;
            if (sda_smp_stb && scl_o) smp_at = c;
            if (period_end) end_at = c;
            @(negedge clk);
        end
        #1;
        chk(t1 == p, "R6 first tick after run", t1, p);
        chk(t2 - t1 == p, "R3 tick spacing", t2 - t1, p);
        chk(ticks == 10, "R4 ticks per SCL period", ticks, 10);
        chk(lows == 5 * p, "R4 low cycles", lows, 5 * p);
        chk(rise == 5 * p + 1, "R4 first high cycle", rise, 5 * p + 1);
        chk(scl_o == 1'b0, "R4 new period starts low", scl_o, 0);
        chk(chg_at == 3 * p, "R5 change strobe cycle", chg_at, 3 * p);
        chk(smp_at == 8 * p, "R5 sample strobe cycle", smp_at, 8 * p);
        chk(end_at == 10 * p, "R5 period end cycle", end_at, 10 * p);
        run = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        int cnt;
        int busy;
        repeat (3) @(negedge clk);
        #1;
        // R1 reset state
        chk(cfg_active == 7'h44, "R1 reset rate word", cfg_active, 7'h44);
        chk(scl_o == 1'b1, "R1 reset scl", scl_o, 1);
        chk(tick == 1'b0, "R1 reset tick", tick, 0);
        @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            run_vector(VECS[i].cfg, int'(VECS[i].per));
        end

        // R6 idle: no ticks, scl high for a stretch with the fastest rate
        idle_write(7'h00);
        cnt = 0;
        busy = 0;
        for (int c = 0; c < 20; c++) begin
            #1;
            if (tick || sda_chg_stb || sda_smp_stb) cnt++;
            if (!scl_o) busy++;
            @(negedge clk);
        end
        chk(cnt == 0, "R6 no strobes while idle", cnt, 0);
        chk(busy == 0, "R6 scl high while idle", busy, 0);

        // R7 write during a transfer is held pending
        run = 1'b1;
        @(negedge clk);
        cfg_we = 1'b1; cfg_wdata = 7'h08;
        @(negedge clk);
        cfg_we = 1'b0;
        cnt = 0;
        busy = 0;
        for (int c = 0; c < 6; c++) begin
            #1;
            if (cfg_active != 7'h00) busy++;
            if (tick) cnt++;
            @(negedge clk);
        end
        chk(busy == 0, "R7 active unchanged during run", busy, 0);
        chk(cnt == 6, "R7 tick spacing unchanged during run", cnt, 6);
        run = 1'b0;
        #1;
        chk(cfg_active == 7'h00, "R7 not yet applied", cfg_active, 7'h00);
        @(negedge clk);
        #1;
        chk(cfg_active == 7'h08, "R7 applied after run falls", cfg_active, 7'h08);

        // R9 soft reset during a transfer, colliding with a write
        idle_write(7'h00);
        run = 1'b1;
        @(negedge clk);
        cfg_we = 1'b1; cfg_wdata = 7'h10;
        @(negedge clk);
        soft_rst = 1'b1; cfg_we = 1'b1; cfg_wdata = 7'h11;
        #1;
        chk(tick == 1'b0, "R9 no tick during soft reset", tick, 0);
        chk(scl_o == 1'b1, "R9 scl high during soft reset", scl_o, 1);
        @(negedge clk);
        soft_rst = 1'b0; cfg_we = 1'b0;
        #1;
        chk(cfg_active == 7'h44, "R9 soft reset beats write", cfg_active, 7'h44);
        cnt = 0;
        for (int c = 1; c <= 400; c++) begin
            if (tick && cnt == 0) cnt = c;
            @(negedge clk);
            #1;
        end
        chk(cnt == 144, "R9 timing restarts at default rate", cnt, 144);
        @(negedge clk);
        run = 1'b0;
        @(negedge clk);
        #1;
        chk(cfg_active == 7'h44, "R9 pending word cleared", cfg_active, 7'h44);

        // R1 asynchronous reset mid-run returns defaults
        idle_write(7'h00);
        run = 1'b1;
        @(negedge clk);
        rst_n = 1'b0;
        run = 1'b0;
        #1;
        chk(cfg_active == 7'h44, "R1 async reset rate word", cfg_active, 7'h44);
        chk(scl_o == 1'b1, "R1 async reset scl", scl_o, 1);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        summary();
    end

endmodule